// File: doc/BRIEF.md
# Half-Rate Register Bus Bridge

This block connects a CPU data port that runs on the core clock to a register bus whose transfers advance at half that rate. It produces the half-rate phase enable itself, a signal that is high on every second core clock. It moves CPU requests onto the register bus only in cycles where that enable is high.

Writes are posted. The CPU gets ready in the same cycle it asks, and the address and data wait in a one-entry buffer until the next enable cycle. Reads stall the CPU. The read strobe goes out on the first enable cycle, and ready returns two clocks after that strobe, so a read costs two extra clocks plus at most one clock of phase alignment. A read, or a second write, that meets a write still waiting in the buffer is held until that write has gone out on the bus. Only then does it start its own access.

Top module: `halfrate_reg_bridge`

## Requirements
- R1: A synchronous active-high reset clears the pending write and the read sequencer and sets the phase enable low. In the first cycle after reset is released `perEn` is 0, `cpuReady`, `perRd` and `perWr` are 0, and in the following cycle `perEn` is 1.
- R2: `perEn` changes value on every core clock cycle while not in reset.
- R3: `perRd` and `perWr` are only asserted in cycles where `perEn` is 1. They are never asserted together. Each transfer holds its strobe for one cycle.
- R4: A write request (`cpuReq`=1, `cpuWe`=1) that finds no write pending gets `cpuReady`=1 in the same cycle.
- R5: An accepted write appears on the bus as `perWr`=1, with `perAddr` and `perWdata` equal to the accepted address and data, in the first cycle after the acceptance cycle in which `perEn` is 1. That is one cycle later if `perEn` was 0 in the acceptance cycle, and two cycles later if it was 1.
- R6: A read request (`cpuWe`=0) that finds no write pending asserts `perRd` with `perAddr` equal to `cpuAddr` in the first cycle at or after the request in which `perEn` is 1. `cpuReady` then follows exactly two cycles after that strobe. The total is two cycles from request to ready if `perEn` was 1 in the request cycle, and three cycles if it was 0.
- R7: A read requested while a write is pending produces no `perRd` until the cycle after that write's `perWr`. It strobes at the next enable cycle, which is two cycles after the `perWr`, and gets ready two cycles later.
- R8: A write requested while another write is pending keeps `cpuReady` at 0 and is accepted in the cycle right after the pending write's `perWr`.
- R9: `cpuReady` is only asserted while `cpuReq` is 1. It stays 0 for every cycle of a read stall.
- R10: In the cycle a read gets ready, `cpuRdata` equals the value the register bus returns for that address, which includes any earlier posted write to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | CPU request, held until ready |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | CPU register address |
| cpuWdata | input | DW | CPU write data |
| cpuRdata | output | DW | Read data, valid when ready on a read |
| cpuReady | output | 1 | Request completes this cycle |
| perEn | output | 1 | Half-rate phase enable |
| perAddr | output | AW | Register bus address |
| perWdata | output | DW | Register bus write data |
| perRd | output | 1 | Register bus read strobe |
| perWr | output | 1 | Register bus write strobe |
| perRdata | input | DW | Register bus read data, held from the edge ending the read strobe |

## Verification
The assertions assume the CPU keeps `cpuReq`, `cpuWe`, `cpuAddr` and `cpuWdata` unchanged from a request until the cycle it sees ready. They also assume the register bus latches read data at the edge that ends the read strobe and holds it until the next read. The stimulus changes CPU inputs only just after a rising edge and only once ready has been seen. It inserts single idle cycles to choose the enable phase of each request. Its bus model captures writes and read data on exactly those edges, so every operation starts from a known phase.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RD_DONE = 2'd2
  } hrbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBuf;  // capture CPU write into the post buffer
    logic selBuf;   // drive bus address from the post buffer
    logic issueWr;  // write strobe on the bus this cycle
    logic issueRd;  // read strobe on the bus this cycle
    logic rdDone;   // read data returns to the CPU this cycle
  } hrbCtl_t;

endpackage

// File: rtl/hrb_phase.sv
module hrb_phase (
  input  logic clk,
  input  logic rst,
  output logic perEn
);

  logic phaseQ;

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= 1'b0;
    else     phaseQ <= ~phaseQ;
  end

  assign perEn = phaseQ;

  AST_PHASE_HIGH_THEN_LOW: assert property (@(posedge clk) disable iff (rst)
    perEn |=> !perEn);  // R2
  AST_PHASE_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
    !perEn |=> perEn);  // R2

endmodule

// File: rtl/hrb_ctrl.sv
module hrb_ctrl
  import hrb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cpuReq,
  input  logic    cpuWe,
  input  logic    perEn,
  output hrbCtl_t ctl,
  output logic    cpuReady
);

  hrbState_t state;
  hrbState_t stateNxt;
  logic      wrPending;
  logic      isIdle;

  assign isIdle = (state == ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.selBuf  = wrPending;
    ctl.issueWr = isIdle && wrPending && perEn;
    ctl.issueRd = isIdle && cpuReq && !cpuWe && !wrPending && perEn;
    ctl.loadBuf = isIdle && cpuReq && cpuWe && !wrPending;
    ctl.rdDone  = (state == ST_RD_DONE);
    cpuReady    = ctl.loadBuf || ctl.rdDone;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (ctl.issueRd) stateNxt = ST_RD_WAIT;
      ST_RD_WAIT: stateNxt = ST_RD_DONE;
      ST_RD_DONE: stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wrPending <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.loadBuf)      wrPending <= 1'b1;
      else if (ctl.issueWr) wrPending <= 1'b0;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ctl.issueRd |-> ##2 cpuReady);  // R6
  AST_RD_STALL: assert property (@(posedge clk) disable iff (rst)
    ctl.issueRd |=> !cpuReady);  // R9
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuReq);  // R9
  AST_WR_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (wrPending && !perEn) |=> ctl.issueWr);  // R5
  AST_POST_HELD: assert property (@(posedge clk) disable iff (rst)
    ctl.loadBuf |=> wrPending);  // R8

endmodule

// File: rtl/hrb_dpath.sv
module hrb_dpath
  import hrb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  hrbCtl_t       ctl,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] perRdata,
  output logic [DW-1:0] cpuRdata,
  output logic [AW-1:0] perAddr,
  output logic [DW-1:0] perWdata,
  output logic          perRd,
  output logic          perWr
);

  logic [AW-1:0] bufAddr;
  logic [DW-1:0] bufData;

  always_ff @(posedge clk) begin
    if (rst) begin
      bufAddr <= '0;
      bufData <= '0;
    end else if (ctl.loadBuf) begin
      bufAddr <= cpuAddr;
      bufData <= cpuWdata;
    end
  end

  assign perAddr  = ctl.selBuf ? bufAddr : cpuAddr;
  assign perWdata = bufData;
  assign perWr    = ctl.issueWr;
  assign perRd    = ctl.issueRd;
  assign cpuRdata = ctl.rdDone ? perRdata : '0;

  AST_BUF_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ctl.selBuf && !ctl.loadBuf) |=> (ctl.selBuf ? $stable(bufAddr) && $stable(bufData) : 1'b1));  // R5

endmodule

// File: rtl/halfrate_reg_bridge.sv
module halfrate_reg_bridge
  import hrb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuReady,
  output logic          perEn,
  output logic [AW-1:0] perAddr,
  output logic [DW-1:0] perWdata,
  output logic          perRd,
  output logic          perWr,
  input  logic [DW-1:0] perRdata
);

  hrbCtl_t ctl;

  hrb_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .perEn (perEn)
  );

  hrb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .perEn    (perEn),
    .ctl      (ctl),
    .cpuReady (cpuReady)
  );

  hrb_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .perRdata (perRdata),
    .cpuRdata (cpuRdata),
    .perAddr  (perAddr),
    .perWdata (perWdata),
    .perRd    (perRd),
    .perWr    (perWr)
  );

  AST_STROBE_ON_EN: assert property (@(posedge clk) disable iff (rst)
    (perRd || perWr) |-> perEn);  // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(perRd && perWr));  // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (perRd || perWr) |=> !(perRd || perWr));  // R3

endmodule

// File: tb/halfrate_reg_bridge_bench.sv
module halfrate_reg_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpuReq = 1'b0;
  logic          cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata;
  logic          cpuReady;
  logic          perEn;
  logic [AW-1:0] perAddr;
  logic [DW-1:0] perWdata;
  logic          perRd;
  logic          perWr;
  logic [DW-1:0] perRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfrate_reg_bridge #(.AW(AW), .DW(DW)) u_halfrate_reg_bridge (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady), .perEn(perEn),
    .perAddr(perAddr), .perWdata(perWdata), .perRd(perRd), .perWr(perWr),
    .perRdata(perRdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] initVal(input int i);
    return DW'(i * 257) ^ DW'(16'h5a3c);
  endfunction

  // register bus model: captures at the edge ending a strobe cycle
  logic [DW-1:0] regFile [NREG];
  logic [DW-1:0] rdReg;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= initVal(i);
      rdReg <= '0;
    end else begin
      if (perEn && perWr) regFile[perAddr] <= perWdata;
      if (perEn && perRd) rdReg <= regFile[perAddr];
    end
  end
  assign perRdata = rdReg;

  // scoreboard state
  logic [DW-1:0]    shadow [NREG];
  logic [DW-1:0]    rdQ [$];
  logic [AW+DW-1:0] wrQ [$];
  logic [AW-1:0]    curAddr = '0;
  int  lastWrCyc = -1;
  int  lastRdCyc = -1;
  logic prevEn = 1'b0;
  bit   started = 1'b0;

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (started) chk(perEn != prevEn, "R2 perEn toggles", perEn, !prevEn);
      prevEn = perEn;
      started = 1'b1;
      if (perRd || perWr)
        chk(perEn && !(perRd && perWr), "R3 strobe only on enable", {perRd, perWr, perEn}, 1);
      if (cpuReady) chk(cpuReq, "R9 ready without request", cpuReq, 1);
      if (perWr) begin
        if (wrQ.size() == 0) chk(1'b0, "R5 unexpected bus write", perAddr, -1);
        else begin
          logic [AW+DW-1:0] e;
          e = wrQ.pop_front();
          chk({perAddr, perWdata} == e, "R5 posted write contents", {perAddr, perWdata}, e);
        end
        lastWrCyc = cyc;
      end
      if (perRd) begin
        lastRdCyc = cyc;
        chk(perAddr == curAddr, "R6 read address", perAddr, curAddr);
      end
      if (cpuReady && cpuReq && !cpuWe) begin
        if (rdQ.size() == 0) chk(1'b0, "R10 unexpected read ready", cpuRdata, -1);
        else begin
          logic [DW-1:0] e;
          e = rdQ.pop_front();
          chk(cpuRdata == e, "R10 read data", cpuRdata, e);
        end
      end
    end
  end

  // driver
  task automatic startCycle(input int want);
    @(posedge clk); #1;
    if (want >= 0 && perEn != want[0]) begin
      cpuReq = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic waitReady(output int c);
    int n = 0;
    forever begin
      @(negedge clk);
      if (cpuReady) break;
      n++;
      if (n > 50) begin
        chk(1'b0, "R9 ready never arrived", n, 0);
        break;
      end
      @(posedge clk); #1;
    end
    c = cyc;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    cpuReq = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input int want,
                         output int reqCyc, output int accCyc, output bit ph);
    startCycle(want);
    ph = perEn;
    reqCyc = cyc;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    waitReady(accCyc);
    shadow[a] = d;
    wrQ.push_back({a, d});
  endtask

  task automatic doRead(input logic [AW-1:0] a, input int want,
                        output int reqCyc, output int rdyCyc, output bit ph);
    startCycle(want);
    ph = perEn;
    reqCyc = cyc;
    curAddr = a;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    rdQ.push_back(shadow[a]);
    waitReady(rdyCyc);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rq, ac, rq2, ac2, rdy, p;
    bit ph, ph2;
    for (int i = 0; i < NREG; i++) shadow[i] = initVal(i);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(perEn == 1'b0, "R1 phase low after reset", perEn, 0);
    chk(!cpuReady && !perRd && !perWr, "R1 outputs idle after reset", {cpuReady, perRd, perWr}, 0);
    @(negedge clk);
    chk(perEn == 1'b1, "R1 phase high second cycle", perEn, 1);

    // R4 / R5: posted writes in both phases
    for (int w = 0; w < 2; w++) begin
      doWrite(AW'(8'h10 + w), DW'(16'hA100 + w), w, rq, ac, ph);
      chk(ac == rq, "R4 write ready same cycle", ac - rq, 0);
      idle(4);
      chk(lastWrCyc == ac + (ph ? 2 : 1), "R5 write issue cycle", lastWrCyc - ac, ph ? 2 : 1);
    end

    // R6 / R10: reads in both phases
    for (int r = 0; r < 2; r++) begin
      doRead(AW'(8'h10 + r), r, rq, rdy, ph);
      chk(rdy - rq == (ph ? 2 : 3), "R6 read latency", rdy - rq, ph ? 2 : 3);
      chk(lastRdCyc == rq + (ph ? 0 : 1), "R6 read strobe cycle", lastRdCyc - rq, ph ? 0 : 1);
      doRead(AW'(8'h33 + r), -1, rq, rdy, ph);
      chk(rdy - rq == (ph ? 2 : 3), "R6 back-to-back read latency", rdy - rq, ph ? 2 : 3);
      idle(3);
    end

    // R7: read right after a posted write, same address
    for (int k = 0; k < 2; k++) begin
      doWrite(AW'(8'h40 + k), DW'(16'hBE00 + k), k, rq, ac, ph);
      doRead(AW'(8'h40 + k), -1, rq2, rdy, ph2);
      p = ac + (ph ? 2 : 1);
      chk(lastWrCyc == p, "R7 write before read", lastWrCyc - ac, p - ac);
      chk(lastRdCyc == p + 2, "R7 read strobe waits for write", lastRdCyc - p, 2);
      chk(rdy == p + 4, "R7 read ready after write", rdy - p, 4);
      idle(3);
    end

    // R8: second write while one is pending
    for (int k = 0; k < 2; k++) begin
      doWrite(AW'(8'h50 + k), DW'(16'hC000 + k), k, rq, ac, ph);
      doWrite(AW'(8'h60 + k), DW'(16'hD000 + k), -1, rq2, ac2, ph2);
      p = ac + (ph ? 2 : 1);
      chk(ac2 == p + 1, "R8 second write accepted after drain", ac2 - ac, p + 1 - ac);
      chk(ac2 > rq2, "R8 second write stalled", ac2 - rq2, 1);
      idle(5);
      doRead(AW'(8'h50 + k), -1, rq, rdy, ph);
      doRead(AW'(8'h60 + k), -1, rq, rdy, ph);
      idle(3);
    end

    idle(6);
    chk(rdQ.size() == 0, "R10 all reads returned", rdQ.size(), 0);
    chk(wrQ.size() == 0, "R5 all writes issued", wrQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule